// File: doc/BRIEF.md
# Correlation-Based Frequency Offset Estimator

The block takes a stream of complex symbols from which the modulation has already been removed, so each has roughly constant magnitude. It returns one estimate of the carrier frequency offset, normalized to the sample rate, for every block of `L_AVG` accepted symbols. Inside a block it forms the products z[k]·conj(z[k−m]) for every lag m from 1 to `N_CORR` and sums them into a single complex correlation S. A pipelined vectoring CORDIC finds arg(S). A constant multiplier then divides the angle by π·(N_CORR+1)·MOD_M.

For blind operation, `MOD_M` is the modulation order (2, 4 or 8), and both the estimate and its unambiguous range shrink by that factor. For data-aided operation `MOD_M` is 1. A synchronous clear abandons the block in progress and any estimates still in the pipeline. After the clear, symbol counting starts again from zero.

Top module: `freq_offset_est`

## Requirements
- R1: `est_o` is a two's-complement fraction of W = clog2(N_CORR)+clog2(MOD_M)+19 bits (23 with the defaults). Its value in cycles per sample is est_o/2^W.
- R2: After reset `valid_o` is 0 and `est_o` is 0.
- R3: Only cycles with `valid_i`=1 are counted. While `valid_i` is 0 the symbol inputs are ignored. One estimate is produced per `L_AVG` accepted symbols.
- R4: Products use only symbols of the same block. Lag m contributes z[k]·conj(z[k−m]) for k = m … L_AVG−1, where k is the symbol's index within its block.
- R5: The estimate equals atan2(Im S, Re S)/(π·(N_CORR+1)·MOD_M), within 2e-6 cycles per sample.
- R6: The full argument range (−π, π] is covered, including the case where S lies in the left half plane.
- R7: `valid_o` is high for exactly one cycle. It rises on clock edge e+CORDIC_ITER+2, where e is the edge that samples the L_AVG-th symbol of a block.
- R8: `clr_i` high at an edge resets the symbol count and the correlation sum, ignores `valid_i` in that cycle, and cancels every estimate not yet presented.
- R9: `est_o` holds its last value while `valid_o` is 0.
- R10: The next block may begin on the cycle after the last symbol of the previous block. Back-to-back blocks lose no symbol and each gives its own estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the estimation in progress |
| valid_i | input | 1 | Symbol qualifier |
| sym_re_i | input | SYM_W | Symbol real part, signed |
| sym_im_i | input | SYM_W | Symbol imaginary part, signed |
| valid_o | output | 1 | One-cycle pulse marking a new estimate |
| est_o | output | EST_W | Normalized frequency offset estimate, signed fraction |

## Verification
The hardest case to reach is a correlation sum in the left half plane near ±π, where the CORDIC pre-rotation and the angle wrap both matter. The bench reaches it with phase steps of ±1.22 rad per symbol, which give an argument of about ±3.05 rad. It also uses 0.8 rad, which gives about 2 rad. A second hard case is a clear that lands while an estimate is still in flight. It is produced by pulsing the clear one cycle and then ten cycles after a block's last symbol. The bench also runs two blocks with no gap between them, with different phase steps, so that any carry-over of delay-line history would skew the second estimate.

// File: rtl/cfo_est_pkg.sv
package cfo_est_pkg;
  // arctan(2^-idx) in angle units where pi = 2^31
  function automatic longint atan_q31(input int idx);
    case (idx)
      0: return 64'd536870912;   1: return 64'd316933406;
      2: return 64'd167458907;   3: return 64'd85004756;
      4: return 64'd42667331;    5: return 64'd21354465;
      6: return 64'd10679838;    7: return 64'd5340245;
      8: return 64'd2670163;     9: return 64'd1335087;
      10: return 64'd667544;     11: return 64'd333772;
      12: return 64'd166886;     13: return 64'd83443;
      14: return 64'd41722;      15: return 64'd20861;
      16: return 64'd10430;      17: return 64'd5215;
      18: return 64'd2608;       19: return 64'd1304;
      20: return 64'd652;        21: return 64'd326;
      22: return 64'd163;        23: return 64'd81;
      24: return 64'd41;         25: return 64'd20;
      26: return 64'd10;         27: return 64'd5;
      28: return 64'd3;          29: return 64'd1;
      default: return 64'd0;
    endcase
  endfunction

  function automatic int est_width(input int n_corr, input int mod_m);
    return $clog2(n_corr) + $clog2(mod_m) + 19;
  endfunction
endpackage

// File: rtl/cfo_corr_acc.sv
module cfo_corr_acc #(
  parameter int N  = 4,
  parameter int L  = 64,
  parameter int SW = 8,
  parameter int AW = 25,
  localparam int CW = $clog2(L)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 vld_i,
  input  logic signed [SW-1:0] re_i,
  input  logic signed [SW-1:0] im_i,
  output logic                 sum_vld_o,
  output logic signed [AW-1:0] sum_re_o,
  output logic signed [AW-1:0] sum_im_o
);
  logic [CW-1:0]         cnt_q;
  logic signed [SW-1:0]  h_re_q [N];
  logic signed [SW-1:0]  h_im_q [N];
  logic signed [AW-1:0]  p_re [N];
  logic signed [AW-1:0]  p_im [N];
  logic signed [AW-1:0]  tap_re, tap_im, acc_re_q, acc_im_q;

  // tap m holds z[k-1-m]; it counts only once the block index exceeds m
  for (genvar m = 0; m < N; m++) begin : g_lag
    logic signed [AW-1:0] a_re, a_im, b_re, b_im;
    logic                 en;
    assign a_re = AW'(re_i);
    assign a_im = AW'(im_i);
    assign b_re = AW'(h_re_q[m]);
    assign b_im = AW'(h_im_q[m]);
    assign en   = (cnt_q > CW'(m));
    assign p_re[m] = en ? (a_re * b_re + a_im * b_im) : '0;
    assign p_im[m] = en ? (a_im * b_re - a_re * b_im) : '0;
  end

  always_comb begin
    tap_re = '0;
    tap_im = '0;
    for (int m = 0; m < N; m++) begin
      tap_re = tap_re + p_re[m];
      tap_im = tap_im + p_im[m];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_re_q  <= '0;
      acc_im_q  <= '0;
      sum_vld_o <= 1'b0;
      sum_re_o  <= '0;
      sum_im_o  <= '0;
      for (int m = 0; m < N; m++) begin
        h_re_q[m] <= '0;
        h_im_q[m] <= '0;
      end
    end else if (clr_i) begin
      cnt_q     <= '0;
      acc_re_q  <= '0;
      acc_im_q  <= '0;
      sum_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= 1'b0;
      if (vld_i) begin
        h_re_q[0] <= re_i;
        h_im_q[0] <= im_i;
        for (int m = 1; m < N; m++) begin
          h_re_q[m] <= h_re_q[m-1];
          h_im_q[m] <= h_im_q[m-1];
        end
        if (cnt_q == CW'(L - 1)) begin
          cnt_q     <= '0;
          acc_re_q  <= '0;
          acc_im_q  <= '0;
          sum_re_o  <= acc_re_q + tap_re;
          sum_im_o  <= acc_im_q + tap_im;
          sum_vld_o <= 1'b1;
        end else begin
          cnt_q    <= cnt_q + 1'b1;
          acc_re_q <= acc_re_q + tap_re;
          acc_im_q <= acc_im_q + tap_im;
        end
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> ($stable(cnt_q) && $stable(acc_re_q) && $stable(acc_im_q))); // R3
endmodule

// File: rtl/cfo_cordic_vec.sv
module cfo_cordic_vec #(
  parameter int AW   = 25,
  parameter int ITER = 16,
  parameter int AF   = 24,
  localparam int XW  = AW + 2,
  localparam int ZW  = AF + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 vld_i,
  input  logic signed [AW-1:0] re_i,
  input  logic signed [AW-1:0] im_i,
  output logic                 vld_o,
  output logic signed [ZW-1:0] ang_o
);
  localparam logic signed [ZW-1:0] HALF_PI = ZW'(64'sd1 <<< (AF - 1));

  logic                 v [ITER+1];
  logic signed [XW-1:0] x [ITER+1];
  logic signed [XW-1:0] y [ITER+1];
  logic signed [ZW-1:0] z [ITER+1];
  logic signed [ZW-1:0] ang_tab [ITER];
  logic signed [XW-1:0] in_re, in_im;

  for (genvar i = 0; i < ITER; i++) begin : g_tab
    assign ang_tab[i] = ZW'(cfo_est_pkg::atan_q31(i) >>> (31 - AF));
  end

  assign in_re = XW'(re_i);
  assign in_im = XW'(im_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= ITER; i++) begin
        v[i] <= 1'b0;
        x[i] <= '0;
        y[i] <= '0;
        z[i] <= '0;
      end
    end else begin
      // pre-rotation by -/+90 degrees folds the left half plane into range
      v[0] <= vld_i & ~clr_i;
      if (!in_re[XW-1]) begin
        x[0] <= in_re;  y[0] <= in_im;  z[0] <= '0;
      end else if (!in_im[XW-1]) begin
        x[0] <= in_im;  y[0] <= -in_re; z[0] <= HALF_PI;
      end else begin
        x[0] <= -in_im; y[0] <= in_re;  z[0] <= -HALF_PI;
      end
      for (int i = 0; i < ITER; i++) begin
        v[i+1] <= v[i] & ~clr_i;
        if (y[i][XW-1]) begin
          x[i+1] <= x[i] - (y[i] >>> i);
          y[i+1] <= y[i] + (x[i] >>> i);
          z[i+1] <= z[i] - ang_tab[i];
        end else begin
          x[i+1] <= x[i] + (y[i] >>> i);
          y[i+1] <= y[i] - (x[i] >>> i);
          z[i+1] <= z[i] + ang_tab[i];
        end
      end
    end
  end

  assign vld_o = v[ITER];
  assign ang_o = z[ITER];

  AST_X_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v[0] |-> !x[0][XW-1]); // R6
endmodule

// File: rtl/cfo_scale.sv
module cfo_scale #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int AF = 24,
  parameter int OW = 23,
  parameter int KS = 18,
  localparam int ZW  = AF + 3,
  localparam int PRW = ZW + KS + 1,
  localparam int D   = (N + 1) * M,
  localparam int SH  = KS + AF - OW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 vld_i,
  input  logic signed [ZW-1:0] ang_i,
  output logic                 vld_o,
  output logic signed [OW-1:0] est_o
);
  localparam longint K   = ((64'sd1 <<< KS) + D / 2) / D;
  localparam longint LIM = ((64'sd1 <<< OW) / D) + 64;

  logic signed [PRW-1:0] prod;
  assign prod = PRW'(ang_i) * PRW'(K);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      est_o <= '0;
    end else begin
      vld_o <= vld_i & ~clr_i;
      if (vld_i && !clr_i) est_o <= OW'(prod >>> SH);
    end
  end

  AST_EST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (longint'(est_o) <= LIM && longint'(est_o) >= -LIM)); // R5
endmodule

// File: rtl/freq_offset_est.sv
module freq_offset_est #(
  parameter int N_CORR     = 4,
  parameter int L_AVG      = 64,
  parameter int MOD_M      = 4,
  parameter int SYM_W      = 8,
  parameter int CORDIC_ITER = 16,
  parameter int ANG_F      = 24,
  localparam int EST_W     = cfo_est_pkg::est_width(N_CORR, MOD_M),
  localparam int ACC_W     = 2 * SYM_W + $clog2(N_CORR * L_AVG) + 1,
  localparam int ANG_W     = ANG_F + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    valid_i,
  input  logic signed [SYM_W-1:0] sym_re_i,
  input  logic signed [SYM_W-1:0] sym_im_i,
  output logic                    valid_o,
  output logic signed [EST_W-1:0] est_o
);
  logic                    sum_vld, ang_vld;
  logic signed [ACC_W-1:0] sum_re, sum_im;
  logic signed [ANG_W-1:0] ang;

  cfo_corr_acc #(.N(N_CORR), .L(L_AVG), .SW(SYM_W), .AW(ACC_W)) u_corr (
    .clk_i, .rst_ni, .clr_i,
    .vld_i(valid_i), .re_i(sym_re_i), .im_i(sym_im_i),
    .sum_vld_o(sum_vld), .sum_re_o(sum_re), .sum_im_o(sum_im)
  );

  cfo_cordic_vec #(.AW(ACC_W), .ITER(CORDIC_ITER), .AF(ANG_F)) u_cordic (
    .clk_i, .rst_ni, .clr_i,
    .vld_i(sum_vld), .re_i(sum_re), .im_i(sum_im),
    .vld_o(ang_vld), .ang_o(ang)
  );

  cfo_scale #(.N(N_CORR), .M(MOD_M), .AF(ANG_F), .OW(EST_W), .KS(18)) u_scale (
    .clk_i, .rst_ni, .clr_i,
    .vld_i(ang_vld), .ang_i(ang),
    .vld_o(valid_o), .est_o(est_o)
  );

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_EST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(est_o)); // R9
  AST_CLR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o); // R8
endmodule

// File: tb/tb_freq_offset_est.sv
module tb_freq_offset_est;
  localparam int N    = 4;
  localparam int L    = 64;
  localparam int M    = 4;
  localparam int SW   = 8;
  localparam int ITER = 16;
  localparam int OW   = 23;          // R1 width for N=4, M=4
  localparam real TOL = 2.0e-6;
  localparam real PI  = 3.14159265358979323846;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0, valid_i = 1'b0;
  logic signed [SW-1:0] sym_re_i = '0, sym_im_i = '0;
  logic valid_o;
  logic signed [OW-1:0] est_o;

  freq_offset_est #(.N_CORR(N), .L_AVG(L), .MOD_M(M), .SYM_W(SW), .CORDIC_ITER(ITER)) dut (
    .clk_i, .rst_ni, .clr_i, .valid_i, .sym_re_i, .sym_im_i, .valid_o, .est_o
  );

  always #10ns clk_i = ~clk_i;

  int errors = 0, checks = 0, cyc = 0;
  bit running = 0, done = 0;
  int blk_a[$], blk_b[$];
  int due_q[$];
  real exp_q[$];
  string tag_q[$];
  string cur_tag = "R5";
  logic signed [OW-1:0] last_est = '0;

  always @(posedge clk_i) cyc++;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference: exact correlation sum over the block, then ideal angle
  task automatic model_add(input int a, input int b, input int edge_no);
    blk_a.push_back(a);
    blk_b.push_back(b);
    if (blk_a.size() == L) begin
      longint sre = 0, sim = 0;
      for (int k = 0; k < L; k++)
        for (int m = 1; m <= N; m++)
          if (k >= m) begin
            sre += longint'(blk_a[k] * blk_a[k-m] + blk_b[k] * blk_b[k-m]);
            sim += longint'(blk_b[k] * blk_a[k-m] - blk_a[k] * blk_b[k-m]);
          end
      due_q.push_back(edge_no + ITER + 2);
      exp_q.push_back($atan2(real'(sim), real'(sre)) / (PI * (N + 1) * M));
      tag_q.push_back(cur_tag);
      blk_a.delete();
      blk_b.delete();
    end
  endtask

  task automatic send(input int a, input int b);
    @(negedge clk_i); #1;
    clr_i = 1'b0; valid_i = 1'b1;
    sym_re_i = SW'(a); sym_im_i = SW'(b);
    model_add(a, b, cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      clr_i = 1'b0; valid_i = 1'b0;
      sym_re_i = SW'($urandom); sym_im_i = SW'($urandom);   // R3 garbage ignored
    end
  endtask

  task automatic clear(input bit with_valid);
    @(negedge clk_i); #1;
    clr_i = 1'b1; valid_i = with_valid;
    sym_re_i = SW'($urandom); sym_im_i = SW'($urandom);
    blk_a.delete(); blk_b.delete();
    due_q.delete(); exp_q.delete(); tag_q.delete();
  endtask

  task automatic burst(input real phi, input real th, input bit gaps, input int nsym);
    for (int k = 0; k < nsym; k++) begin
      send($rtoi($floor(90.0 * $cos(phi * k + th) + 0.5)),
           $rtoi($floor(90.0 * $sin(phi * k + th) + 0.5)));
      if (gaps && (k % 5 == 2)) idle(2);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk_i) begin
    if (running && rst_ni) begin
      bit exp_v;
      while (due_q.size() > 0 && due_q[0] < cyc) begin
        errors++; checks++;
        $display("FAIL %s R7 missed estimate: act=none exp=edge %0d", tag_q[0], due_q[0]);
        void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      exp_v = (due_q.size() > 0 && due_q[0] == cyc);
      checks++;
      if (valid_o !== exp_v) begin
        errors++;
        $display("FAIL R7/R8 valid_o at edge %0d: act=%b exp=%b", cyc, valid_o, exp_v);
      end
      if (exp_v) begin
        real e, got;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front(); void'(due_q.pop_front());
        if (valid_o) begin
          got = real'(est_o) / real'(64'd1 << OW);
          checks++;
          if (got - e > TOL || e - got > TOL) begin
            errors++;
            $display("FAIL %s estimate: act=%f exp=%f", t, got, e);
          end
        end
      end else if (!valid_o) begin
        checks++;
        if (est_o !== last_est) begin
          errors++;
          $display("FAIL R9 hold: act=%0d exp=%0d", est_o, last_est);
        end
      end
      if (valid_o) last_est = est_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R7 watchdog expired: act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || est_o !== '0) begin
      errors++;
      $display("FAIL R2 reset: act=%b/%0d exp=0/0", valid_o, est_o);
    end
    running = 1;

    cur_tag = "R1 R5";   burst(0.30, 0.2, 0, L);  idle(25);
    cur_tag = "R3 R5";   burst(-0.50, 1.0, 1, L); idle(25);
    cur_tag = "R6";      burst(1.22, 0.0, 0, L);  idle(25);
    cur_tag = "R6 neg";  burst(-1.22, 2.0, 1, L); idle(25);
    cur_tag = "R4 R10";  burst(0.8, 0.5, 0, L);
                         burst(-0.1, 2.5, 0, L);  idle(25);
    // R8: clear mid-block, with a valid symbol in the clear cycle
    cur_tag = "R8";      burst(0.6, 0.0, 0, 20);
    clear(1'b1);         burst(0.15, 0.3, 0, L);  idle(25);
    // R8: clear right after the last symbol and mid-pipeline
    burst(0.4, 0.0, 0, L); clear(1'b0); idle(30);
    burst(0.4, 0.0, 0, L); idle(10); clear(1'b0); idle(30);
    cur_tag = "R8 after"; burst(-0.9, 1.0, 0, L); idle(ITER + 10);

    checks++;
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending estimates: act=%0d exp=0", due_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule